// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel that copies 32-bit words from a source address to a destination address. The work is described by descriptors: five words giving a next-link word, a byte count, a source address, a destination address and a configuration word. Software loads the first descriptor into the channel's registers through a simple write port. Writing the configuration register with its enable bit set starts the channel.

Each word is read from the source and then written to the destination over one shared memory port. At the end of a node the channel looks at the link word. If the chain flag is set, it fetches the next descriptor from memory. If the flag is clear, it stops. A chain whose last link points back at its first node runs without end, and it reports a node event for every descriptor that asks for one. While the channel runs, the remaining byte count and the current link word can be read on dedicated outputs.

Top module: `lldma_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `mem_req`, `node_done` and `chain_done` are low, and `cur_count` and `cur_link` read zero.
- R2: Register select codes are 0 link, 1 count, 2 source, 3 destination and 4 configuration. A configuration write with bit 0 set while idle starts the channel, which then moves count/4 words. Each word is a read at the source address followed by a write of that data at the destination address.
- R3: Configuration bit 31 makes the source address advance by 4 after each word, and bit 30 does the same for the destination. When a bit is clear, that address stays fixed for the whole node.
- R4: When a node ends with link bit 1 set, the channel reads five words starting at the link address with its low 5 bits forced to zero. The words are taken in order as link, count, source, destination and configuration, and the channel then runs the new node. Bit 0 of a fetched configuration word does not change the enable state.
- R5: When a node ends with link bit 1 clear, `chain_done` pulses high for exactly one cycle, the enable bit clears by itself and `busy` falls.
- R6: `node_done` pulses for one cycle at the end of each node whose configuration bit 1 is set. It does not pulse for a node whose bit 1 is clear.
- R7: A chain whose last link points back to its first node keeps running and keeps producing node events, and it never pulses `chain_done`.
- R8: A configuration write with bit 0 clear while busy stops the channel at the next word boundary. No further node or chain event is produced, and the words not yet copied are never written.
- R9: `cur_count` gives the remaining byte count of the active node and falls by 4 as each word is written. `cur_link` gives the link word of the active node.
- R10: The count field is 13 bits wide and holds up to 0x1FFC. A node with count 0 does no memory access and ends at once with its events.
- R11: A memory access completes only in a cycle where `mem_ready` is high. While it is low, the request and its address are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 link, 1 count, 2 source, 3 destination, 4 configuration) |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid in the cycle the read completes |
| busy | output | 1 | Channel active |
| cur_count | output | CW | Remaining bytes of the active node |
| cur_link | output | AW | Link word of the active node |
| node_done | output | 1 | Node-completion pulse |
| chain_done | output | 1 | End-of-chain pulse |

## Verification
Some properties are checked on every cycle. A request is only raised while the channel is busy. A completed write lowers the remaining count by exactly four. A fixed source address holds still across a word. The channel is idle in the cycle after an end-of-chain pulse. Other behaviour needs whole scenarios from the bench. These include copied memory contents under each increment mode, descriptor fetch from an unaligned link word, the number of node events over a multi-node chain, endless cyclic running, and an abort that leaves the tail of a buffer untouched.

// File: rtl/lldma_chan.sv
module lldma_chan #(
  parameter int AW = 32,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic [CW-1:0] cur_count,
  output logic [AW-1:0] cur_link,
  output logic          node_done,
  output logic          chain_done
);
  localparam logic [CW-1:0] WSTEP = CW'(4);
  localparam logic [AW-1:0] ASTEP = AW'(4);
  localparam logic [2:0]    LASTW = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_END} st_t;

  st_t           st;
  logic [2:0]    fidx;
  logic          en_q, irq_q, sinc_q, dinc_q;
  logic [AW-1:0] link_q, src_q, dst_q, fbase_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   buf_q;
  logic          unused_bits;

  assign unused_bits = ^{reg_wdata[29:2], mem_rdata[29:2]};

  assign busy       = (st != S_IDLE);
  assign mem_req    = ((st == S_FETCH) || (st == S_RD)) ? en_q : (st == S_WR);
  assign mem_we     = (st == S_WR);
  assign mem_wdata  = buf_q;
  assign mem_addr   = (st == S_FETCH) ? {fbase_q[AW-1:5], fidx, 2'b00} :
                      (st == S_WR)    ? dst_q : src_q;
  assign cur_count  = cnt_q;
  assign cur_link   = link_q;
  assign node_done  = (st == S_END) && en_q && irq_q;
  assign chain_done = (st == S_END) && en_q && !link_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fidx    <= '0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      link_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      fbase_q <= '0;
      cnt_q   <= '0;
      buf_q   <= '0;
    end else begin
      if (reg_wr && (reg_sel == 3'd4) && (st != S_IDLE))
        en_q <= reg_wdata[0];
      case (st)
        S_IDLE: begin
          if (reg_wr) begin
            case (reg_sel)
              3'd0: link_q <= reg_wdata[AW-1:0];
              3'd1: cnt_q  <= reg_wdata[CW-1:0];
              3'd2: src_q  <= reg_wdata[AW-1:0];
              3'd3: dst_q  <= reg_wdata[AW-1:0];
              3'd4: begin
                en_q   <= reg_wdata[0];
                irq_q  <= reg_wdata[1];
                dinc_q <= reg_wdata[30];
                sinc_q <= reg_wdata[31];
                if (reg_wdata[0])
                  st <= (cnt_q == '0) ? S_END : S_RD;
              end
              default: ;
            endcase
          end
        end
        S_FETCH: begin
          if (!en_q) begin
            st <= S_IDLE;
          end else if (mem_ready) begin
            case (fidx)
              3'd0: link_q <= mem_rdata[AW-1:0];
              3'd1: cnt_q  <= mem_rdata[CW-1:0];
              3'd2: src_q  <= mem_rdata[AW-1:0];
              3'd3: dst_q  <= mem_rdata[AW-1:0];
              default: begin
                irq_q  <= mem_rdata[1];
                dinc_q <= mem_rdata[30];
                sinc_q <= mem_rdata[31];
              end
            endcase
            fidx <= fidx + 3'd1;
            if (fidx == LASTW)
              st <= (cnt_q == '0) ? S_END : S_RD;
          end
        end
        S_RD: begin
          if (!en_q) begin
            st <= S_IDLE;
          end else if (mem_ready) begin
            buf_q <= mem_rdata;
            st    <= S_WR;
          end
        end
        S_WR: begin
          if (mem_ready) begin
            cnt_q <= (cnt_q <= WSTEP) ? '0 : cnt_q - WSTEP;
            if (sinc_q) src_q <= src_q + ASTEP;
            if (dinc_q) dst_q <= dst_q + ASTEP;
            st <= (cnt_q <= WSTEP) ? S_END : S_RD;
          end
        end
        S_END: begin
          if (!en_q) begin
            st <= S_IDLE;
          end else if (link_q[1]) begin
            fbase_q <= {link_q[AW-1:5], 5'b0};
            fidx    <= '0;
            st      <= S_FETCH;
          end else begin
            en_q <= 1'b0;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && mem_ready && cnt_q > WSTEP) |=> cur_count == $past(cur_count) - WSTEP);

  p_fixed_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && mem_ready && !sinc_q) |=> src_q == $past(src_q));

  p_chain_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !busy);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && st != S_FETCH && en_q) |=> mem_req && $stable(mem_addr));
endmodule

// File: tb/test_lldma_chan.sv
module test_lldma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, node_done, chain_done;
  logic [12:0] cur_count;
  logic [31:0] cur_link;

  logic [31:0] mem [0:1023];
  logic        bw_en = 1'b0;
  logic [31:0] bw_addr = '0, bw_data = '0;
  logic        stall_en = 1'b0, tog = 1'b0;
  int n_cmp = 0, n_bad = 0, n_node = 0, n_chain = 0, cyc = 0;

  always #5 clk = ~clk;

  lldma_chan i_lldma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .cur_count(cur_count),
    .cur_link(cur_link), .node_done(node_done), .chain_done(chain_done));

  assign mem_ready = stall_en ? tog : 1'b1;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    tog <= ~tog;
    cyc <= cyc + 1;
    if (bw_en) mem[bw_addr[11:2]] <= bw_data;
    else if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;
    if (node_done) n_node <= n_node + 1;
    if (chain_done) n_chain <= n_chain + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
      $finish;
    end
  end

  // src[28:17] count[16:4] src_inc[3] dst_inc[2] node_evt[1] stall[0]
  localparam logic [28:0] VEC [0:5] = '{
    {12'h100, 13'd16, 4'b1110},
    {12'h104, 13'd4,  4'b1100},
    {12'h108, 13'd12, 4'b0110},
    {12'h10C, 13'd12, 4'b1000},
    {12'h120, 13'd32, 4'b1111},
    {12'h100, 13'd0,  4'b1110}
  };

  function automatic logic [31:0] pat(input int a);
    return 32'hC0DE_0000 ^ (a * 32'h0001_0003);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = 32'(a); bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic prog(input logic [31:0] l, c, s, d, cf);
    wr(3'd0, l); wr(3'd1, c); wr(3'd2, s); wr(3'd3, d); wr(3'd4, cf);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    int b_node, b_chain, bad;
    logic [31:0] em [0:63];
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req", 32'(mem_req), 0);
    chk("R1 count", 32'(cur_count), 0);
    chk("R1 link", cur_link, 0);
    chk("R1 pulses", 32'({node_done, chain_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 32'h100; a < 32'h300; a += 4) poke(a, pat(a));

    for (int v = 0; v < 6; v++) begin
      logic [11:0] s0; logic [12:0] c0; logic si, di, ne, stl;
      {s0, c0, si, di, ne, stl} = VEC[v];
      for (int a = 32'h400; a < 32'h500; a += 4) poke(a, 32'h0);
      for (int k = 0; k < 64; k++) em[k] = 32'h0;
      for (int k = 0; k < int'(c0) / 4; k++)
        em[di ? k : 0] = pat(int'(s0) + (si ? 4 * k : 0));
      stall_en = stl;
      b_node = n_node; b_chain = n_chain;
      prog(32'h0, 32'(c0), 32'(s0), 32'h400, {si, di, 28'h0, ne, 1'b1});
      wait_idle();
      stall_en = 1'b0;
      bad = 0;
      for (int k = 0; k < 64; k++) if (mem[256 + k] !== em[k]) bad++;
      chk($sformatf("R2 R3 R10 R11 vec%0d data mismatches", v), 32'(bad), 0);
      chk($sformatf("R5 vec%0d chain events", v), 32'(n_chain - b_chain), 1);
      chk($sformatf("R6 vec%0d node events", v), 32'(n_node - b_node), 32'(ne));
    end

    // R4 R6: three-node chain, unaligned link bits
    for (int a = 32'h400; a < 32'h460; a += 4) poke(a, 32'h0);
    poke(32'h800, 32'h0000_085A); poke(32'h804, 12); poke(32'h808, 32'h120);
    poke(32'h80C, 32'h420); poke(32'h810, 32'hC000_0001);
    poke(32'h840, 32'h0000_0001); poke(32'h844, 4); poke(32'h848, 32'h140);
    poke(32'h84C, 32'h440); poke(32'h850, 32'hC000_0002);
    b_node = n_node; b_chain = n_chain;
    prog(32'h0000_0802, 8, 32'h100, 32'h400, 32'hC000_0003);
    wait_idle();
    bad = 0;
    if (mem[256] !== pat(32'h100) || mem[257] !== pat(32'h104)) bad++;
    for (int k = 0; k < 3; k++) if (mem[264 + k] !== pat(32'h120 + 4 * k)) bad++;
    if (mem[267] !== 32'h0) bad++;
    if (mem[272] !== pat(32'h140)) bad++;
    chk("R4 chained data mismatches", 32'(bad), 0);
    chk("R6 chain node events", 32'(n_node - b_node), 2);
    chk("R5 chain end events", 32'(n_chain - b_chain), 1);
    chk("R9 final link", cur_link, 32'h1);

    // R7 cyclic then R8 abort
    poke(32'h880, 32'h0000_08A2); poke(32'h884, 8); poke(32'h888, 32'h100);
    poke(32'h88C, 32'h500); poke(32'h890, 32'hC000_0003);
    poke(32'h8A0, 32'h0000_0882); poke(32'h8A4, 4); poke(32'h8A8, 32'h110);
    poke(32'h8AC, 32'h510); poke(32'h8B0, 32'hC000_0001);
    b_node = n_node; b_chain = n_chain;
    prog(32'h0000_08A2, 8, 32'h100, 32'h500, 32'hC000_0003);
    for (int i = 0; i < 3000 && (n_node - b_node) < 5; i++) @(negedge clk);
    chk("R7 cyclic node events", 32'((n_node - b_node) >= 5), 1);
    chk("R7 still busy", 32'(busy), 1);
    chk("R7 no chain end", 32'(n_chain - b_chain), 0);
    wr(3'd4, 32'h0);
    b_node = n_node; b_chain = n_chain;
    repeat (3) @(negedge clk);
    chk("R8 cyclic abort idle", 32'(busy), 0);
    repeat (20) @(negedge clk);
    chk("R8 cyclic abort events", 32'((n_node - b_node) + (n_chain - b_chain)), 0);

    // R8 abort mid-node
    for (int a = 32'h600; a < 32'h700; a += 4) poke(a, 32'h0);
    b_node = n_node; b_chain = n_chain;
    prog(32'h0, 256, 32'h100, 32'h600, 32'hC000_0003);
    repeat (21) @(negedge clk);
    wr(3'd4, 32'h0);
    repeat (3) @(negedge clk);
    chk("R8 abort idle", 32'(busy), 0);
    chk("R8 abort events", 32'((n_node - b_node) + (n_chain - b_chain)), 0);
    chk("R8 tail untouched", mem[(32'h6FC) >> 2], 32'h0);
    chk("R8 head copied", mem[(32'h600) >> 2], pat(32'h100));

    // R9 R10 progress on a maximum-size node, fixed addresses
    poke(32'h700, 32'h0);
    b_chain = n_chain;
    prog(32'h0, 32'h1FFC, 32'h100, 32'h700, 32'h0000_0001);
    chk("R9 R10 count at start", 32'(cur_count), 32'h1FFC);
    repeat (10) @(negedge clk);
    chk("R9 count after five words", 32'(cur_count), 32'h1FE8);
    chk("R9 link readback", cur_link, 32'h0);
    wait_idle();
    chk("R3 fixed address data", mem[(32'h700) >> 2], pat(32'h100));
    chk("R5 max node end", 32'(n_chain - b_chain), 1);
    chk("R9 count drained", 32'(cur_count), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule